// File: doc/BRIEF.md
# SPI Bit-Rate Divisor Search Engine

This block finds a pair of clock divisors for a serial peripheral interface master. The first divisor, the prescale value, runs from 2 to 253. The second, the rate value, runs from 0 to 254. The serial bit rate they give is the reference clock frequency divided by prescale × (1 + rate), using integer division that rounds toward zero. Software or a configuration sequencer supplies the reference frequency and the wanted bit rate as 32-bit unsigned integers, then pulses start. When done pulses, it reads the chosen pair.

The search has two passes that scan the candidates in different orders. Each pass evaluates one candidate per clock. The test compares the target with the quotient through multiplication, so no division happens inside the scan loop. The first pass walks prescale fastest inside rate. It stops on an exact hit, which ends the whole search. Otherwise it stops on the first rate that falls below the target. The second pass walks rate fastest inside prescale and stops on the first candidate at or below the target. Two restoring dividers then work out the two candidates' actual rates in parallel. The one from the first pass wins ties. If the second pass finds nothing, the engine returns the last pair it tried and flags an error.

Top module: `spi_rate_search`

## Requirements
- R1: The rate of a candidate is floor(ref / (prescale × (1 + rate))). Every comparison and the final choice use this value.
- R2: The first pass visits prescale 2..253 for each rate 0..254 in turn, rate held while prescale advances. It ends at the first candidate whose rate is below the target. If it runs out, it ends on its last candidate (253, 254).
- R3: A first-pass candidate whose rate equals the target ends the search at once. That pair is the result, no second pass runs, and done rises in the cycle that candidate is evaluated.
- R4: The second pass visits rate 0..254 for each prescale 2..253 in turn, prescale held while rate advances. It ends at the first candidate whose rate is at or below the target.
- R5: After both passes, the first-pass pair is returned if its rate is greater than or equal to the second-pass rate. Otherwise the second-pass pair is returned.
- R6: busy is high from the cycle after an accepted start until the cycle done is high. done is a single-cycle pulse with busy low. The result outputs hold their value until the next done.
- R7: A start while busy is ignored, and so are changes on the frequency inputs during a search. The result depends only on the values captured with the accepted start.
- R8: If the second pass runs out, the result is (253, 254) and err is high together with done.
- R9: After reset, busy, done and err are low and both result outputs are zero.
- R10: Count a start as cycle 0, and let N1 and N2 be the candidates evaluated in each pass. done is high N1 cycles later on an exact hit, N1+N2 cycles later on an error, and N1+N2+33 cycles later otherwise (one divider load, 32 quotient steps, one select).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a search; taken only when idle |
| ref_hz_i | input | 32 | Reference clock frequency |
| tgt_hz_i | input | 32 | Requested bit rate |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No second-pass candidate reached the target; valid with done |
| cps_o | output | 8 | Chosen prescale value |
| scr_o | output | 8 | Chosen rate value |

## Verification
The bench goes after four corner cases. The first is an exact hit on the very first candidate: an engine that skipped the exact check would run a pointless second pass and report late. The second is a target reached only in the second pass at a divisor product the first pass never visits: a reversed selection rule or an off-by-one in either scan order would return the wrong pair or a wrong latency. The third is a tie between two different pairs, which catches a strict comparison that hands the win to the second pass. The fourth is a target too small to reach, which runs both passes to their ends and catches a wrong last index or a missing err. A second start with altered frequencies in the middle of a run would restart or corrupt the search if the engine did not latch its inputs.

// File: rtl/rsrch_pkg.sv
package rsrch_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_P1   = 2'd1,
    S_P2   = 2'd2,
    S_DIV  = 2'd3
  } rs_state_e;
endpackage

// File: rtl/rsrch_walker.sv
// Candidate index stepper: two nested loops whose nesting order is chosen per pass.
module rsrch_walker #(
  parameter int IDX_W     = 8,
  parameter int CPS_FIRST = 2,
  parameter int CPS_LAST  = 253,
  parameter int SCR_FIRST = 0,
  parameter int SCR_LAST  = 254
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             step_i,
  input  logic             scr_major_i,
  output logic [IDX_W-1:0] cps_o,
  output logic [IDX_W-1:0] scr_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] CF = IDX_W'(CPS_FIRST);
  localparam logic [IDX_W-1:0] CL = IDX_W'(CPS_LAST);
  localparam logic [IDX_W-1:0] SF = IDX_W'(SCR_FIRST);
  localparam logic [IDX_W-1:0] SL = IDX_W'(SCR_LAST);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] cps_q, cps_d, scr_q, scr_d;
  logic cps_end, scr_end;

  assign cps_end = (cps_q == CL);
  assign scr_end = (scr_q == SL);
  assign last_o  = cps_end && scr_end;
  assign cps_o   = cps_q;
  assign scr_o   = scr_q;

  always_comb begin
    cps_d = cps_q;
    scr_d = scr_q;
    if (restart_i) begin
      cps_d = CF;
      scr_d = SF;
    end else if (step_i) begin
      if (scr_major_i) begin
        if (cps_end) begin
          cps_d = CF;
          scr_d = scr_q + ONE;
        end else begin
          cps_d = cps_q + ONE;
        end
      end else begin
        if (scr_end) begin
          scr_d = SF;
          cps_d = cps_q + ONE;
        end else begin
          scr_d = scr_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cps_q <= CF;
      scr_q <= SF;
    end else if (restart_i || step_i) begin
      cps_q <= cps_d;
      scr_q <= scr_d;
    end
  end

  // R2: in the first-pass order, rate holds while prescale advances
  p_inner_cps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i && scr_major_i && !cps_end) |=> $stable(scr_q));
  // R4: in the second-pass order, prescale holds while rate advances
  p_inner_scr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !restart_i && !scr_major_i && !scr_end) |=> $stable(cps_q));
  // R2: indices never leave their ranges
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cps_q >= CF) && (cps_q <= CL) && (scr_q >= SF) && (scr_q <= SL));
endmodule

// File: rtl/rsrch_eval.sv
// Compares floor(ref / p) against the target through products, with p = cps * (1 + scr).
module rsrch_eval #(
  parameter int REF_W = 32,
  parameter int IDX_W = 8
) (
  input  logic [REF_W-1:0]     ref_i,
  input  logic [REF_W-1:0]     tgt_i,
  input  logic [IDX_W-1:0]     cps_i,
  input  logic [IDX_W-1:0]     scr_i,
  output logic [2*IDX_W:0]     prod_o,
  output logic                 exact_o,
  output logic                 below_o,
  output logic                 at_or_below_o
);
  localparam int PROD_W = 2 * IDX_W + 1;
  localparam int WIDE_W = REF_W + PROD_W;

  logic [IDX_W:0]    scr_p1;
  logic [WIDE_W-1:0] lo, hi, refx;

  assign scr_p1 = {1'b0, scr_i} + {{IDX_W{1'b0}}, 1'b1};
  assign prod_o = {{(IDX_W+1){1'b0}}, cps_i} * {{IDX_W{1'b0}}, scr_p1};
  // floor(ref/p) == t  <=>  t*p <= ref < (t+1)*p
  assign lo     = {{PROD_W{1'b0}}, tgt_i} * {{REF_W{1'b0}}, prod_o};
  assign hi     = lo + {{REF_W{1'b0}}, prod_o};
  assign refx   = {{PROD_W{1'b0}}, ref_i};

  assign exact_o       = (lo <= refx) && (refx < hi);
  assign below_o       = (refx < lo);
  assign at_or_below_o = (refx < hi);
endmodule

// File: rtl/rsrch_div.sv
// Restoring divider, one quotient bit per clock.
module rsrch_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic [NUM_W-1:0] quo_o,
  output logic             fin_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);
  localparam int CHK_W = NUM_W + DEN_W + 1;

  logic [NUM_W-1:0] quo_q, quo_d, num_q;
  logic [DEN_W-1:0] rem_q, rem_d, den_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q;
  logic [DEN_W:0]   trial, diff;
  logic             fits;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = (trial >= {1'b0, den_q});

  always_comb begin
    quo_d = {quo_q[NUM_W-2:0], fits};
    rem_d = fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
    cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      num_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (go_i) begin
      quo_q <= num_i;
      rem_q <= '0;
      num_q <= num_i;
      den_q <= den_i;
      cnt_q <= CNT_W'(NUM_W);
      run_q <= 1'b1;
    end else if (run_q && (cnt_q != '0)) begin
      quo_q <= quo_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign quo_o = quo_q;
  assign fin_o = run_q && (cnt_q == '0);

  // R1: a finished quotient is the floor of the captured ratio
  p_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o |-> (({{(DEN_W+1){1'b0}}, quo_q} * {{(NUM_W+1){1'b0}}, den_q}) <= {{(DEN_W+1){1'b0}}, num_q})
           && ({{(DEN_W+1){1'b0}}, num_q} < (({{(DEN_W+1){1'b0}}, quo_q} + CHK_W'(1)) * {{(NUM_W+1){1'b0}}, den_q})));
endmodule

// File: rtl/spi_rate_search.sv
module spi_rate_search
  import rsrch_pkg::*;
#(
  parameter int REF_W     = 32,
  parameter int IDX_W     = 8,
  parameter int CPS_FIRST = 2,
  parameter int CPS_LAST  = 253,
  parameter int SCR_FIRST = 0,
  parameter int SCR_LAST  = 254
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [REF_W-1:0] ref_hz_i,
  input  logic [REF_W-1:0] tgt_hz_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [IDX_W-1:0] cps_o,
  output logic [IDX_W-1:0] scr_o
);
  localparam int PROD_W = 2 * IDX_W + 1;

  rs_state_e        state_q, state_d;
  logic [REF_W-1:0] ref_q, ref_d, tgt_q, tgt_d;
  logic [IDX_W-1:0] c1_cps_q, c1_cps_d, c1_scr_q, c1_scr_d;
  logic [IDX_W-1:0] c2_cps_q, c2_cps_d, c2_scr_q, c2_scr_d;
  logic [PROD_W-1:0] c1_prod_q, c1_prod_d;
  logic             done_q, done_d, err_q, err_d;
  logic [IDX_W-1:0] cps_q, cps_d, scr_q, scr_d;

  logic             w_restart, w_step, w_last;
  logic [IDX_W-1:0] cur_cps, cur_scr;
  logic [PROD_W-1:0] cur_prod;
  logic             hit_eq, hit_lt, hit_le;
  logic             div_go, fin1, fin2;
  logic [REF_W-1:0] q1, q2;

  rsrch_walker #(
    .IDX_W(IDX_W), .CPS_FIRST(CPS_FIRST), .CPS_LAST(CPS_LAST),
    .SCR_FIRST(SCR_FIRST), .SCR_LAST(SCR_LAST)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .restart_i(w_restart), .step_i(w_step),
    .scr_major_i(state_q == S_P1), .cps_o(cur_cps), .scr_o(cur_scr), .last_o(w_last)
  );

  rsrch_eval #(.REF_W(REF_W), .IDX_W(IDX_W)) u_eval (
    .ref_i(ref_q), .tgt_i(tgt_q), .cps_i(cur_cps), .scr_i(cur_scr),
    .prod_o(cur_prod), .exact_o(hit_eq), .below_o(hit_lt), .at_or_below_o(hit_le)
  );

  rsrch_div #(.NUM_W(REF_W), .DEN_W(PROD_W)) u_div1 (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(ref_q), .den_i(c1_prod_q),
    .quo_o(q1), .fin_o(fin1)
  );

  rsrch_div #(.NUM_W(REF_W), .DEN_W(PROD_W)) u_div2 (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(ref_q), .den_i(cur_prod),
    .quo_o(q2), .fin_o(fin2)
  );

  always_comb begin
    state_d   = state_q;
    ref_d     = ref_q;
    tgt_d     = tgt_q;
    c1_cps_d  = c1_cps_q;
    c1_scr_d  = c1_scr_q;
    c1_prod_d = c1_prod_q;
    c2_cps_d  = c2_cps_q;
    c2_scr_d  = c2_scr_q;
    cps_d     = cps_q;
    scr_d     = scr_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    w_restart = 1'b0;
    w_step    = 1'b0;
    div_go    = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          ref_d     = ref_hz_i;
          tgt_d     = tgt_hz_i;
          w_restart = 1'b1;
          state_d   = S_P1;
        end
      end
      S_P1: begin
        if (hit_eq) begin
          cps_d   = cur_cps;
          scr_d   = cur_scr;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end else if (hit_lt || w_last) begin
          c1_cps_d  = cur_cps;
          c1_scr_d  = cur_scr;
          c1_prod_d = cur_prod;
          w_restart = 1'b1;
          state_d   = S_P2;
        end else begin
          w_step = 1'b1;
        end
      end
      S_P2: begin
        if (hit_le) begin
          c2_cps_d = cur_cps;
          c2_scr_d = cur_scr;
          div_go   = 1'b1;
          state_d  = S_DIV;
        end else if (w_last) begin
          cps_d   = cur_cps;
          scr_d   = cur_scr;
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = S_IDLE;
        end else begin
          w_step = 1'b1;
        end
      end
      S_DIV: begin
        if (fin1 && fin2) begin
          cps_d   = (q1 >= q2) ? c1_cps_q : c2_cps_q;
          scr_d   = (q1 >= q2) ? c1_scr_q : c2_scr_q;
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      ref_q     <= '0;
      tgt_q     <= '0;
      c1_cps_q  <= '0;
      c1_scr_q  <= '0;
      c1_prod_q <= '0;
      c2_cps_q  <= '0;
      c2_scr_q  <= '0;
      cps_q     <= '0;
      scr_q     <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      state_q   <= state_d;
      ref_q     <= ref_d;
      tgt_q     <= tgt_d;
      c1_cps_q  <= c1_cps_d;
      c1_scr_q  <= c1_scr_d;
      c1_prod_q <= c1_prod_d;
      c2_cps_q  <= c2_cps_d;
      c2_scr_q  <= c2_scr_d;
      cps_q     <= cps_d;
      scr_q     <= scr_d;
      done_q    <= done_d;
      err_q     <= err_d;
    end
  end

  assign busy_o = (state_q != S_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;
  assign cps_o  = cps_q;
  assign scr_o  = scr_q;

  // R6: done lasts one cycle and never overlaps busy
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_busy_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
  // R8: err only accompanies done
  p_err_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R7: a start during the later phases never restarts the first pass
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == S_P2 || state_q == S_DIV) && start_i) |=> (state_q != S_P1));
  // R3: an exact first-pass hit finishes on the next edge without error
  p_exact_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_P1 && hit_eq) |=> (done_o && !err_o && !busy_o));
  // R5: first-pass pair wins when its rate is not lower
  p_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DIV && fin1 && fin2 && (q1 >= q2)) |=>
      (cps_o == $past(c1_cps_q)) && (scr_o == $past(c1_scr_q)));
endmodule

// File: tb/spi_rate_search_test.sv
module spi_rate_search_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ref_hz = '0;
  logic [31:0] tgt_hz = '0;
  logic        busy, done, err;
  logic [7:0]  cps, scr;

  int checks = 0;
  int fails  = 0;

  spi_rate_search uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ref_hz_i(ref_hz), .tgt_hz_i(tgt_hz),
    .busy_o(busy), .done_o(done), .err_o(err), .cps_o(cps), .scr_o(scr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: result pair, err flag and done latency (R1..R5, R8, R10)
  task automatic model(input longint r, input longint t,
                       output int ecps, output int escr, output bit eerr, output int ed);
    int n1 = 0, n2 = 0, c1 = 0, s1 = 0, c2 = 0, s2 = 0;
    longint f1 = 0, f2 = 0;
    bit stop1 = 0, exact = 0, stop2 = 0;
    for (int s = 0; s <= 254 && !stop1; s++)
      for (int c = 2; c <= 253 && !stop1; c++) begin
        longint f = r / (c * (1 + s));
        n1++; c1 = c; s1 = s; f1 = f;
        if (f == t) begin exact = 1; stop1 = 1; end
        else if (f < t) stop1 = 1;
      end
    eerr = 0;
    if (exact) begin
      ecps = c1; escr = s1; ed = n1;
      return;
    end
    for (int c = 2; c <= 253 && !stop2; c++)
      for (int s = 0; s <= 254 && !stop2; s++) begin
        longint f = r / (c * (1 + s));
        n2++; c2 = c; s2 = s; f2 = f;
        if (f <= t) stop2 = 1;
      end
    if (!stop2) begin
      eerr = 1; ecps = c2; escr = s2; ed = n1 + n2;
    end else begin
      ed = n1 + n2 + 33;
      if (f1 >= f2) begin ecps = c1; escr = s1; end
      else begin ecps = c2; escr = s2; end
    end
  endtask

  task automatic run_case(input string tag, input longint r, input longint t, input int poke_at);
    int ecps, escr, ed;
    bit eerr;
    model(r, t, ecps, escr, eerr, ed);
    @(negedge clk);
    start = 1'b1; ref_hz = 32'(r); tgt_hz = 32'(t);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= ed; k++) begin
      @(posedge clk); #1;
      chk(busy == (k < ed), "R6", "busy", longint'(busy), longint'(k < ed));
      chk(done == (k == ed), "R10", "done", longint'(done), longint'(k == ed));
      if (k == ed) begin
        chk(cps == 8'(ecps), tag, "cps", longint'(cps), longint'(ecps));
        chk(scr == 8'(escr), tag, "scr", longint'(scr), longint'(escr));
        chk(err == eerr, "R8", "err", longint'(err), longint'(eerr));
      end
      if (poke_at > 0 && k == poke_at) begin  // R7: start and new inputs mid-run
        start = 1'b1; ref_hz = 32'd12345678; tgt_hz = 32'd999;
      end
      if (poke_at > 0 && k == poke_at + 1) start = 1'b0;
    end
    @(posedge clk); #1;
    chk(!done && !busy, "R6", "done/busy after pulse", longint'({done, busy}), 0);
    chk(cps == 8'(ecps) && scr == 8'(escr), "R6", "result held",
        longint'({cps, scr}), longint'({8'(ecps), 8'(escr)}));
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(!busy && !done && !err, "R9", "flags in reset", longint'({busy, done, err}), 0);
    chk(cps == 0 && scr == 0, "R9", "result in reset", longint'({cps, scr}), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !done && !err, "R9", "flags after release", longint'({busy, done, err}), 0);

    run_case("R3", 100000000, 50000000, 0);   // exact hit on the first candidate
    run_case("R3", 120000000, 10000000, 0);   // exact hit later in the first row
    run_case("R7", 100000000, 7000000, 3);    // first pass wins; mid-run start ignored
    run_case("R4", 508000, 1000, 0);          // second pass wins with an unvisited product (R5)
    run_case("R5", 100000, 300, 0);           // tie between distinct pairs goes to pass one
    run_case("R2", 1000000, 1000, 0);         // exact hit in the fourth row (R1)
    run_case("R8", 1000000000, 1, 0);         // both passes run out

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule